// File: doc/BRIEF.md
# Presettable Up/Down Counter with Dual Clear

A small synchronous counter that steps up or down, can be preset from a data word, and can be cleared in two ways. One clear acts at once, with no clock. The other acts on the next rising clock edge. The count leaves the block through tri-state drivers, so several counters can share one set of wires.

An active-low carry flag marks the terminal state so that stages can be chained. To chain them, tie the carry of one stage to the T enable of the next. One parameter sets the modulus: 16 gives a binary counter and 10 gives a decade counter.

The clocked operations have a fixed priority:

- synchronous clear first,
- then load,
- then count,
- otherwise hold.

The asynchronous clear overrides all of them at any time.

Top module: `updn_counter`

## Requirements
- R1: While `aclr_n` is low the count is 0 immediately, between clock edges and whatever the other inputs do, and it stays 0 across rising edges.
- R2: With `aclr_n` high, `sclr_n` low at a rising edge makes the count 0, even if load or count is also requested.
- R3: With both clears high, `load_n` low at a rising edge copies `d` into the count (`d[0]` least significant), even if counting is enabled.
- R4: With both clears and load high, the count advances only when `enp_n` and `ent_n` are both low; if either is high the count holds.
- R5: Counting up (`up` = 1) adds one; from MODULUS-1 (15 binary, 9 decade) it wraps to 0.
- R6: Counting down (`up` = 0) subtracts one; from 0 it wraps to MODULUS-1 (15 binary, 9 decade).
- R7: In decade mode a loaded value from 10 to 15 counts up as plain binary (10→11…15→0), so the counter returns to the decade range.
- R8: `rco_n` is low exactly when `ent_n` is low and the count is at the terminal value for the direction (MODULUS-1 when up, 0 when down). `rco_n` is never high-impedance.
- R9: When `oe_n` is high, all bits of `q` are high-impedance and the internal count keeps operating. When `oe_n` is low, `q` shows the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; clocked operations happen on its rising edge |
| aclr_n | input | 1 | Asynchronous clear, active low |
| sclr_n | input | 1 | Synchronous clear, active low |
| load_n | input | 1 | Parallel load, active low |
| d | input | WIDTH | Preset data, bit 0 least significant |
| enp_n | input | 1 | Count enable P, active low |
| ent_n | input | 1 | Count enable T, active low; also gates the carry |
| up | input | 1 | Direction: 1 up, 0 down |
| oe_n | input | 1 | Output enable for `q`, active low |
| q | output | WIDTH | Count value, tri-state |
| rco_n | output | 1 | Terminal-count carry, active low |

## Verification
Several control requests can arrive at the same clock edge. The important pairs are a clear with a load, and a load with an enabled count. The asynchronous clear can also land just before an edge at which a load is requested.

The bench sets up these pairs with directed cycles. It also uses random stimulus in which each control is low with a set probability, so such pairs occur often. A reference model in the bench applies the clear, load, count, hold priority at each edge and predicts the result for a binary and a decade instance that run side by side. The asynchronous case is judged by reading `q` between edges.

// File: rtl/updn_pkg.sv
package updn_pkg;
  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_CLR   = 2'd1,
    OP_LOAD  = 2'd2,
    OP_COUNT = 2'd3
  } op_t;
endpackage

// File: rtl/updn_ctrl.sv
module updn_ctrl
  import updn_pkg::*;
(
  input  logic sclr_n,
  input  logic load_n,
  input  logic enp_n,
  input  logic ent_n,
  output op_t  op
);
  always_comb begin
    if (!sclr_n)             op = OP_CLR;
    else if (!load_n)        op = OP_LOAD;
    else if (!enp_n && !ent_n) op = OP_COUNT;
    else                     op = OP_HOLD;
  end
endmodule

// File: rtl/updn_next.sv
module updn_next #(
  parameter int WIDTH   = 4,
  parameter int MODULUS = 16
) (
  input  logic [WIDTH-1:0] cur,
  output logic [WIDTH-1:0] inc,
  output logic [WIDTH-1:0] dec
);
  localparam logic [WIDTH-1:0] MAXV = WIDTH'(MODULUS - 1);

  generate
    if (MODULUS == (1 << WIDTH)) begin : g_binary
      always_comb begin
        inc = cur + 1'b1;
        dec = cur - 1'b1;
      end
    end else begin : g_modulo
      always_comb begin
        // values above MAXV step as plain binary and roll over at 2**WIDTH
        inc = (cur == MAXV) ? '0 : cur + 1'b1;
        dec = (cur == '0) ? MAXV : cur - 1'b1;
      end
    end
  endgenerate
endmodule

// File: rtl/updn_outstage.sv
module updn_outstage #(
  parameter int WIDTH   = 4,
  parameter int MODULUS = 16
) (
  input  logic             clk,
  input  logic             aclr_n,
  input  logic [WIDTH-1:0] cnt,
  input  logic             ent_n,
  input  logic             up,
  output logic             rco_n
);
  localparam logic [WIDTH-1:0] MAXV = WIDTH'(MODULUS - 1);

  logic at_term;

  always_comb begin
    at_term = up ? (cnt == MAXV) : (cnt == '0);
    rco_n   = ~(at_term & ~ent_n);
  end

  // R8: the carry is never low while the T enable is high
  p_rco_gate_r8: assert property (@(posedge clk) disable iff (!aclr_n)
    ent_n |-> rco_n);
endmodule

// File: rtl/updn_counter.sv
module updn_counter
  import updn_pkg::*;
#(
  parameter int WIDTH   = 4,
  parameter int MODULUS = 16
) (
  input  logic             clk,
  input  logic             aclr_n,
  input  logic             sclr_n,
  input  logic             load_n,
  input  logic [WIDTH-1:0] d,
  input  logic             enp_n,
  input  logic             ent_n,
  input  logic             up,
  input  logic             oe_n,
  output logic [WIDTH-1:0] q,
  output logic             rco_n
);
  localparam logic [WIDTH-1:0] MAXV = WIDTH'(MODULUS - 1);

  op_t              op;
  logic [WIDTH-1:0] cnt;
  logic [WIDTH-1:0] inc;
  logic [WIDTH-1:0] dec;

  updn_ctrl u_ctrl (
    .sclr_n (sclr_n),
    .load_n (load_n),
    .enp_n  (enp_n),
    .ent_n  (ent_n),
    .op     (op)
  );

  updn_next #(.WIDTH(WIDTH), .MODULUS(MODULUS)) u_next (
    .cur (cnt),
    .inc (inc),
    .dec (dec)
  );

  always_ff @(posedge clk or negedge aclr_n) begin
    if (!aclr_n) begin
      cnt <= '0;
    end else begin
      unique case (op)
        OP_CLR:   cnt <= '0;
        OP_LOAD:  cnt <= d;
        OP_COUNT: cnt <= up ? inc : dec;
        default:  cnt <= cnt;
      endcase
    end
  end

  assign q = oe_n ? {WIDTH{1'bz}} : cnt;

  updn_outstage #(.WIDTH(WIDTH), .MODULUS(MODULUS)) u_out (
    .clk    (clk),
    .aclr_n (aclr_n),
    .cnt    (cnt),
    .ent_n  (ent_n),
    .up     (up),
    .rco_n  (rco_n)
  );

  logic cnt_req;
  assign cnt_req = sclr_n && load_n && !enp_n && !ent_n;

  p_sync_clear_r2: assert property (@(posedge clk) disable iff (!aclr_n)
    !sclr_n |=> cnt == '0);
  p_load_r3: assert property (@(posedge clk) disable iff (!aclr_n)
    (sclr_n && !load_n) |=> cnt == $past(d));
  p_hold_r4: assert property (@(posedge clk) disable iff (!aclr_n)
    (sclr_n && load_n && (enp_n || ent_n)) |=> $stable(cnt));
  p_up_wrap_r5: assert property (@(posedge clk) disable iff (!aclr_n)
    (cnt_req && up && cnt == MAXV) |=> cnt == '0);
  p_down_wrap_r6: assert property (@(posedge clk) disable iff (!aclr_n)
    (cnt_req && !up && cnt == '0) |=> cnt == MAXV);
endmodule

// File: tb/updn_counter_bench.sv
`timescale 1ns/1ps
module updn_counter_bench;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       aclr_n = 1'b1, sclr_n = 1'b1, load_n = 1'b1;
  logic       enp_n = 1'b1, ent_n = 1'b1, up = 1'b1, oe_n = 1'b0;
  logic [3:0] d = 4'd0;
  logic [3:0] q_bin, q_dec;
  logic       rco_bin, rco_dec;
  logic [3:0] m_bin = 4'd0, m_dec = 4'd0;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  updn_counter #(.WIDTH(4), .MODULUS(16)) u_updn_counter (
    .clk(clk), .aclr_n(aclr_n), .sclr_n(sclr_n), .load_n(load_n), .d(d),
    .enp_n(enp_n), .ent_n(ent_n), .up(up), .oe_n(oe_n), .q(q_bin), .rco_n(rco_bin));

  updn_counter #(.WIDTH(4), .MODULUS(10)) u_updn_counter_dec (
    .clk(clk), .aclr_n(aclr_n), .sclr_n(sclr_n), .load_n(load_n), .d(d),
    .enp_n(enp_n), .ent_n(ent_n), .up(up), .oe_n(oe_n), .q(q_dec), .rco_n(rco_dec));

  function automatic logic [3:0] model_next(logic [3:0] cur, int modulus);
    if (!sclr_n) return 4'd0;
    if (!load_n) return d;
    if (enp_n || ent_n) return cur;
    if (up) return (cur == 4'(modulus - 1)) ? 4'd0 : cur + 4'd1;
    return (cur == 4'd0) ? 4'(modulus - 1) : cur - 4'd1;
  endfunction

  function automatic logic model_rco(logic [3:0] cur, int modulus);
    logic term;
    term = up ? (cur == 4'(modulus - 1)) : (cur == 4'd0);
    return !(term && !ent_n);
  endfunction

  task automatic chk(string tag, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic compare(string tag);
    if (!oe_n) begin
      chk({tag, " bin"}, q_bin, m_bin);
      chk({tag, " dec"}, q_dec, m_dec);
    end else begin
      chk("R9 hi-z bin", q_bin, 4'bzzzz);
      chk("R9 hi-z dec", q_dec, 4'bzzzz);
    end
    chk("R8 carry bin", {3'b0, rco_bin}, {3'b0, model_rco(m_bin, 16)});
    chk("R8 carry dec", {3'b0, rco_dec}, {3'b0, model_rco(m_dec, 10)});
  endtask

  // one clock: inputs already set; model steps at the edge, outputs read at the falling edge
  task automatic cycle(string tag);
    @(posedge clk);
    if (aclr_n) begin
      m_bin = model_next(m_bin, 16);
      m_dec = model_next(m_dec, 10);
    end else begin
      m_bin = 4'd0;
      m_dec = 4'd0;
    end
    @(negedge clk);
    compare(tag);
  endtask

  task automatic drive(logic s, logic l, logic [3:0] dv, logic p, logic t, logic u, logic o);
    sclr_n = s; load_n = l; d = dv; enp_n = p; ent_n = t; up = u; oe_n = o;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #1 aclr_n = 1'b0;
    @(negedge clk); @(negedge clk);
    compare("R1 reset state");
    aclr_n = 1'b1;

    // R5 / R7: load 14, count up through 15 and wrap
    drive(1, 0, 4'd14, 0, 0, 1, 0); cycle("R3 load 14");
    drive(1, 1, 4'd0, 0, 0, 1, 0);  cycle("R7 up 14->15");
    cycle("R5 R7 up 15->0");
    // R5 decade wrap at 9
    drive(1, 0, 4'd9, 0, 0, 1, 0);  cycle("R3 load 9");
    drive(1, 1, 4'd0, 0, 0, 1, 0);  cycle("R5 up from 9");
    // R6 down wrap from 0
    drive(1, 0, 4'd0, 0, 0, 0, 0);  cycle("R3 load 0");
    drive(1, 1, 4'd0, 0, 0, 0, 0);  cycle("R6 down from 0");
    cycle("R6 down step");
    // R2 clear beats load and count
    drive(0, 0, 4'd7, 0, 0, 1, 0);  cycle("R2 clear over load");
    // R3 load beats count
    drive(1, 0, 4'd5, 0, 0, 1, 0);  cycle("R3 load over count");
    // R4 either enable high holds
    drive(1, 1, 4'd0, 1, 0, 1, 0);  cycle("R4 hold enp high");
    drive(1, 1, 4'd0, 0, 1, 1, 0);  cycle("R4 hold ent high");
    // R9 outputs off while counting, count continues
    drive(1, 1, 4'd0, 0, 0, 1, 1);  cycle("R9 off"); cycle("R9 off");
    oe_n = 1'b0; #0.5; compare("R9 count advanced while off");
    // R1 async clear between edges, with a load pending
    @(negedge clk);
    drive(1, 0, 4'd11, 0, 0, 1, 0);
    #1 aclr_n = 1'b0;
    #0.5;
    m_bin = 4'd0; m_dec = 4'd0;
    compare("R1 clear between edges");
    cycle("R1 clear over load at edge");
    aclr_n = 1'b1;

    // random mix
    void'($urandom(32'd20240613));
    for (int i = 0; i < 600; i++) begin
      aclr_n = ($urandom % 20) != 0;
      drive(($urandom % 8) != 0, ($urandom % 6) != 0, 4'($urandom),
            ($urandom % 5) == 0, ($urandom % 5) == 0, 1'($urandom),
            ($urandom % 6) == 0);
      cycle("R4 R5 R6 random");
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule